// File: doc/BRIEF.md
# Variable-Length Instruction Field Decoder

This block sits behind the fetch stage of a small in-order processor. Each cycle the fetch logic may present the six bytes found at the program counter together with that counter value. The decoder splits those bytes into the fields the later stages use, which are the operation class, the function selector, two register indices and a 32-bit constant. It also reports whether each register index names a real register, how many bytes the instruction occupies, and the address of the next sequential instruction.

Instructions are either two or six bytes long, and the length depends only on the operation class. Six-byte forms carry a constant in bytes 2 to 5, with the most significant byte first. Only eight registers exist, so a register nibble of 8 or above means that field is unused. Operation classes 12 to 15 are undefined. The decoder marks them as illegal and leaves the program counter where it is.

Results are registered. They appear one clock after the request and stay in place until the next request arrives.

Top module: `ifd_decoder`

## Requirements
- R1: `op_class` equals bits 7:4 of byte 0 and `op_func` equals bits 3:0 of byte 0. Byte 0 is `fetch_bytes[47:40]`.
- R2: `reg_a` equals bits 7:4 of byte 1 and `reg_b` equals bits 3:0 of byte 1. Byte 1 is `fetch_bytes[39:32]`.
- R3: `reg_a_used` and `reg_b_used` are 1 exactly when the matching nibble is below 8 and the operation class is legal.
- R4: `instr_len` is 2 for classes 0, 1, 2, 6, 9, 10 and 11. It is 6 for classes 3, 4, 5, 7 and 8.
- R5: For six-byte classes, `imm_value` holds bytes 2 to 5 with byte 2 as the most significant byte, taken from `fetch_bytes[31:0]`. For all other classes it is 0, whatever the trailing bytes contain.
- R6: `next_pc` equals `fetch_pc + instr_len` modulo 2^32, so it wraps past the top of the address space.
- R7: Classes 12 to 15 set `illegal` to 1 and give `instr_len` 0, `next_pc` equal to `fetch_pc`, both register-used flags 0 and `imm_value` 0. Legal classes give `illegal` 0.
- R8: A request sampled with `fetch_valid` high at a clock edge drives `dec_valid` high and shows its results after that same edge. Results come out one per request, in request order.
- R9: A clock edge that samples `fetch_valid` low drives `dec_valid` low and leaves every decoded field unchanged.
- R10: During reset (`rst_n` low at a clock edge) `dec_valid`, `illegal` and all decoded fields become 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_valid | input | 1 | Request present this cycle |
| fetch_pc | input | 32 | Address of byte 0 |
| fetch_bytes | input | 48 | Six fetched bytes, byte 0 in bits 47:40 |
| dec_valid | output | 1 | Decoded results belong to a new request |
| op_class | output | 4 | Operation class nibble |
| op_func | output | 4 | Function selector nibble |
| reg_a | output | 4 | First register nibble |
| reg_b | output | 4 | Second register nibble |
| reg_a_used | output | 1 | First register nibble names a register |
| reg_b_used | output | 1 | Second register nibble names a register |
| imm_value | output | 32 | Constant or displacement |
| instr_len | output | 3 | Instruction length in bytes |
| next_pc | output | 32 | Address of the next sequential instruction |
| illegal | output | 1 | Undefined operation class |

## Verification
The hardest cases to reach are those where the fields contradict each other. Examples are a two-byte instruction whose trailing bytes are not zero, an undefined class whose register nibbles are below 8, and a six-byte instruction fetched near the top of the address space, where the next address wraps. The stimulus reaches them directly. It walks all sixteen classes with deliberately noisy register bytes and trailing bytes, adds program counters near 2^32, and places idle gaps between requests so the hold behaviour is observed separately from back-to-back decoding.

// File: rtl/ifd_pkg.sv
// Shared types and constants for the instruction field decoder.
// Assumes the fixed instruction format: class/function in byte 0,
// register pair in byte 1, optional constant in bytes 2 onward.
package ifd_pkg;

    // Length class of an operation
    typedef enum logic [1:0] {
        LC_SHORT = 2'd0,
        LC_LONG  = 2'd1,
        LC_BAD   = 2'd2
    } len_cls_e;

    // Operation class codes
    localparam logic [3:0] OPC_HALT  = 4'h0;
    localparam logic [3:0] OPC_NOP   = 4'h1;
    localparam logic [3:0] OPC_RMOVE = 4'h2;
    localparam logic [3:0] OPC_IMM   = 4'h3;
    localparam logic [3:0] OPC_STORE = 4'h4;
    localparam logic [3:0] OPC_LOAD  = 4'h5;
    localparam logic [3:0] OPC_ALU   = 4'h6;
    localparam logic [3:0] OPC_JUMP  = 4'h7;
    localparam logic [3:0] OPC_CALL  = 4'h8;
    localparam logic [3:0] OPC_RET   = 4'h9;
    localparam logic [3:0] OPC_PUSH  = 4'hA;
    localparam logic [3:0] OPC_POP   = 4'hB;

endpackage

// File: rtl/ifd_opcode_class.sv
// Maps an operation class nibble to its length class.
// Assumes 4-bit classes. Codes without a definition map to LC_BAD.
module ifd_opcode_class
    import ifd_pkg::*;
(
    input  logic [3:0] opc,
    output len_cls_e   cls
);

    // Classify each defined code. Anything else is undefined.
    always_comb begin
        unique case (opc)
            OPC_HALT, OPC_NOP, OPC_RMOVE, OPC_ALU,
            OPC_RET, OPC_PUSH, OPC_POP:             cls = LC_SHORT;
            OPC_IMM, OPC_STORE, OPC_LOAD,
            OPC_JUMP, OPC_CALL:                     cls = LC_LONG;
            default:                                cls = LC_BAD;
        endcase
    end

endmodule

// File: rtl/ifd_field_split.sv
// Splits the fetched byte window into nibble fields and a big-endian
// constant. Assumes byte 0 sits in the most significant bits of the
// window and that the constant starts at byte CONST_OFS.
module ifd_field_split #(
    parameter int NBYTES    = 6,
    parameter int CONST_W   = 32,
    parameter int CONST_OFS = 2
) (
    input  logic [NBYTES*8-1:0] win,
    output logic [3:0]          opc,
    output logic [3:0]          fn,
    output logic [3:0]          ra,
    output logic [3:0]          rb,
    output logic [CONST_W-1:0]  raw_const
);

    localparam int CBYTES = CONST_W / 8;

    logic [7:0] byte_q [NBYTES];

    // Slice the window into bytes, byte 0 first.
    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        assign byte_q[i] = win[(NBYTES-1-i)*8 +: 8];
    end

    // Assemble the constant, with the first byte as the most significant.
    for (genvar j = 0; j < CBYTES; j++) begin : g_const
        assign raw_const[(CBYTES-1-j)*8 +: 8] = byte_q[CONST_OFS+j];
    end

    assign opc = byte_q[0][7:4];
    assign fn  = byte_q[0][3:0];
    assign ra  = byte_q[1][7:4];
    assign rb  = byte_q[1][3:0];

endmodule

// File: rtl/ifd_reg_flag.sv
// Tells whether a register nibble names an existing register.
// Assumes registers are numbered 0 to NREGS-1.
module ifd_reg_flag #(
    parameter int RW    = 4,
    parameter int NREGS = 8
) (
    input  logic [RW-1:0] idx,
    input  logic          legal,
    output logic          used
);

    // A register is in use only when its index is in range and the class is legal.
    always_comb used = legal && (32'(idx) < NREGS);

endmodule

// File: rtl/ifd_seq_pc.sv
// Sequential next-address adder. It wraps modulo 2^AW.
module ifd_seq_pc #(
    parameter int AW = 32,
    parameter int LW = 3
) (
    input  logic [AW-1:0] pc,
    input  logic [LW-1:0] len,
    output logic [AW-1:0] npc
);

    // Add the zero-extended length to the current address.
    always_comb npc = pc + AW'(len);

endmodule

// File: rtl/ifd_decoder.sv
// Top of the instruction field decoder. It decodes one fetched window
// per request and registers the results, so they appear one clock
// later and are held until the next request. Reset is synchronous
// and active low.
module ifd_decoder
    import ifd_pkg::*;
#(
    parameter int AW        = 32,
    parameter int NBYTES    = 6,
    parameter int CONST_W   = 32,
    parameter int NREGS     = 8,
    parameter int SHORT_LEN = 2,
    parameter int LONG_LEN  = 6,
    parameter int LW        = $clog2(LONG_LEN + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fetch_valid,
    input  logic [AW-1:0]       fetch_pc,
    input  logic [NBYTES*8-1:0] fetch_bytes,
    output logic                dec_valid,
    output logic [3:0]          op_class,
    output logic [3:0]          op_func,
    output logic [3:0]          reg_a,
    output logic [3:0]          reg_b,
    output logic                reg_a_used,
    output logic                reg_b_used,
    output logic [CONST_W-1:0]  imm_value,
    output logic [LW-1:0]       instr_len,
    output logic [AW-1:0]       next_pc,
    output logic                illegal
);

    localparam int CONST_OFS = 2;

    logic [3:0]         opc_c, fn_c, ra_c, rb_c;
    logic [CONST_W-1:0] raw_c, imm_c;
    len_cls_e           cls_c;
    logic               legal_c;
    logic [LW-1:0]      len_c;
    logic [AW-1:0]      npc_c;
    logic [1:0]         used_c;
    logic [3:0]         ridx_c [2];

    ifd_field_split #(
        .NBYTES(NBYTES), .CONST_W(CONST_W), .CONST_OFS(CONST_OFS)
    ) split_i (
        .win(fetch_bytes), .opc(opc_c), .fn(fn_c),
        .ra(ra_c), .rb(rb_c), .raw_const(raw_c)
    );

    ifd_opcode_class class_i (.opc(opc_c), .cls(cls_c));

    assign legal_c   = (cls_c != LC_BAD);
    assign ridx_c[0] = ra_c;
    assign ridx_c[1] = rb_c;

    // One register check per register field.
    for (genvar k = 0; k < 2; k++) begin : g_rflag
        ifd_reg_flag #(.RW(4), .NREGS(NREGS)) flag_i (
            .idx(ridx_c[k]), .legal(legal_c), .used(used_c[k])
        );
    end

    // Choose the length and gate the constant by length class.
    always_comb begin
        unique case (cls_c)
            LC_SHORT: begin len_c = LW'(SHORT_LEN); imm_c = '0;    end
            LC_LONG:  begin len_c = LW'(LONG_LEN);  imm_c = raw_c; end
            default:  begin len_c = '0;             imm_c = '0;    end
        endcase
    end

    ifd_seq_pc #(.AW(AW), .LW(LW)) seq_i (
        .pc(fetch_pc), .len(len_c), .npc(npc_c)
    );

    // Output register: load on a request and hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            op_class   <= '0;
            op_func    <= '0;
            reg_a      <= '0;
            reg_b      <= '0;
            reg_a_used <= 1'b0;
            reg_b_used <= 1'b0;
            imm_value  <= '0;
            instr_len  <= '0;
            next_pc    <= '0;
            illegal    <= 1'b0;
        end else begin
            dec_valid <= fetch_valid;
            if (fetch_valid) begin
                op_class   <= opc_c;
                op_func    <= fn_c;
                reg_a      <= ra_c;
                reg_b      <= rb_c;
                reg_a_used <= used_c[0];
                reg_b_used <= used_c[1];
                imm_value  <= imm_c;
                instr_len  <= len_c;
                next_pc    <= npc_c;
                illegal    <= !legal_c;
            end
        end
    end

endmodule

// File: rtl/ifd_decoder_chk.sv
// Assertion checker for ifd_decoder, attached with bind. The flag
// "armed" goes high one clock after reset is released, so that $past
// never looks at values from before reset.
module ifd_decoder_chk #(
    parameter int AW      = 32,
    parameter int NBYTES  = 6,
    parameter int CONST_W = 32,
    parameter int LW      = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                fetch_valid,
    input logic [AW-1:0]       fetch_pc,
    input logic [NBYTES*8-1:0] fetch_bytes,
    input logic                dec_valid,
    input logic [3:0]          op_class,
    input logic [3:0]          reg_a,
    input logic [3:0]          reg_b,
    input logic                reg_a_used,
    input logic                reg_b_used,
    input logic [CONST_W-1:0]  imm_value,
    input logic [LW-1:0]       instr_len,
    input logic [AW-1:0]       next_pc,
    input logic                illegal
);

    logic armed;

    // Mark the cycles in which the previous sample came after reset.
    always_ff @(posedge clk) armed <= rst_n;

    assert_len_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && dec_valid && !illegal) |-> (instr_len == 3'd2 || instr_len == 3'd6));

    assert_next_pc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && dec_valid) |-> (next_pc == $past(fetch_pc) + AW'(instr_len)));

    assert_bad_class_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && dec_valid && illegal) |->
        (!reg_a_used && !reg_b_used && imm_value == '0 && instr_len == '0 && op_class >= 4'hC));

    assert_reg_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_a_used -> reg_a < 4'd8) && (reg_b_used -> reg_b < 4'd8)));

    assert_short_const_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && instr_len != 3'd6) |-> (imm_value == '0));

    assert_valid_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (dec_valid == $past(fetch_valid)));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(fetch_valid)) |-> ($stable(next_pc) && $stable(op_class) && $stable(imm_value)));

endmodule

bind ifd_decoder ifd_decoder_chk #(
    .AW(AW), .NBYTES(NBYTES), .CONST_W(CONST_W), .LW(LW)
) chk_i (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid),
    .fetch_pc(fetch_pc), .fetch_bytes(fetch_bytes),
    .dec_valid(dec_valid), .op_class(op_class),
    .reg_a(reg_a), .reg_b(reg_b),
    .reg_a_used(reg_a_used), .reg_b_used(reg_b_used),
    .imm_value(imm_value), .instr_len(instr_len),
    .next_pc(next_pc), .illegal(illegal)
);

// File: tb/ifd_decoder_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench for ifd_decoder. A driver task sends requests and
// queues the expected results. A monitor pops and compares them at
// each falling edge where dec_valid is high.
module ifd_decoder_tb_top;

    typedef struct {
        logic [3:0]  opc, fn, ra, rb;
        logic        rav, rbv, ill;
        logic [31:0] cst, npc;
        logic [2:0]  len;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic [47:0] fetch_bytes = '0;
    logic        dec_valid, reg_a_used, reg_b_used, illegal;
    logic [3:0]  op_class, op_func, reg_a, reg_b;
    logic [31:0] imm_value, next_pc;
    logic [2:0]  instr_len;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 0;
    exp_t q[$];
    exp_t last;

    always #2 clk = ~clk;

    ifd_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid),
        .fetch_pc(fetch_pc), .fetch_bytes(fetch_bytes),
        .dec_valid(dec_valid), .op_class(op_class), .op_func(op_func),
        .reg_a(reg_a), .reg_b(reg_b), .reg_a_used(reg_a_used),
        .reg_b_used(reg_b_used), .imm_value(imm_value),
        .instr_len(instr_len), .next_pc(next_pc), .illegal(illegal)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference model written from the requirements.
    function automatic exp_t model(input logic [31:0] pc, input logic [47:0] b);
        exp_t e;
        e.opc = b[47:44];
        e.fn  = b[43:40];
        e.ra  = b[39:36];
        e.rb  = b[35:32];
        e.ill = (e.opc >= 4'hC);
        if (e.ill) e.len = 3'd0;
        else if (e.opc inside {4'h3, 4'h4, 4'h5, 4'h7, 4'h8}) e.len = 3'd6;
        else e.len = 3'd2;
        e.rav = !e.ill && (e.ra < 4'd8);
        e.rbv = !e.ill && (e.rb < 4'd8);
        e.cst = (e.len == 3'd6) ? b[31:0] : 32'h0;
        e.npc = pc + {29'd0, e.len};
        return e;
    endfunction

    task automatic send(input logic [31:0] pc, input logic [47:0] b);
        @(negedge clk);
        fetch_valid = 1'b1;
        fetch_pc    = pc;
        fetch_bytes = b;
        q.push_back(model(pc, b));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            fetch_valid = 1'b0;
            fetch_pc    = 32'hDEAD_0000 + i;
            fetch_bytes = 48'h6C_12_AB_CD_EF_01;
        end
    endtask

    // Monitor: compare every produced result against the queue front.
    always @(negedge clk) begin
        if (rst_n && dec_valid) begin
            if (q.size() == 0) begin
                chk("R8 unexpected result", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                last = e;
                chk("R1 class/func", {op_class, op_func}, {e.opc, e.fn});
                chk("R2 reg nibbles", {reg_a, reg_b}, {e.ra, e.rb});
                chk("R3 reg used", {reg_a_used, reg_b_used}, {e.rav, e.rbv});
                chk("R4 length", instr_len, e.len);
                chk("R5 constant", imm_value, e.cst);
                chk("R6 next pc", next_pc, e.npc);
                chk("R7 illegal", illegal, e.ill);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 reset valid", dec_valid, 1'b0);
        chk("R10 reset fields", {op_class, reg_a, reg_b, instr_len, illegal, reg_a_used}, '0);
        chk("R10 reset pc/const", {next_pc, imm_value}, 64'd0);
        rst_n = 1'b1;

        // Worked encodings
        send(32'h0000_0100, 48'h61_01_FF_FF_FF_FF);   // subtract, trailing noise
        send(32'h0000_0102, 48'h30_80_00_00_05_00);   // immediate load 0x500
        send(32'h0000_0108, 48'h75_88_00_00_10_00);   // jump ge to 0x1000
        idle(2);
        // R9: fields hold after idle edges
        chk("R9 valid low", dec_valid, 1'b0);
        chk("R9 next pc hold", next_pc, last.npc);
        chk("R9 const hold", imm_value, last.cst);

        // Walk every class with noisy bytes, back to back.
        for (int c = 0; c < 16; c++) begin
            send(32'h0000_2000 + 32'(c * 16),
                 {4'(c), 4'(15 - c), 4'(c[2:0]), 4'(c + 5), 32'hA5C3_0000 | 32'(c)});
        end
        // Undefined classes with in-range registers (R7)
        send(32'h0000_3000, 48'hC0_12_11_22_33_44);
        send(32'h0000_3004, 48'hF7_07_00_00_00_01);
        // Wrap near the top of memory (R6)
        send(32'hFFFF_FFFE, 48'h80_FF_12_34_56_78);
        send(32'hFFFF_FFFF, 48'h10_FF_00_00_00_00);
        send(32'hFFFF_FFFC, 48'h4_0_3_7_DE_AD_BE_EF);
        idle(1);
        send(32'h0000_0040, 48'hA0_5F_99_99_99_99);   // push
        send(32'h0000_0042, 48'hB3_F8_77_77_77_77);   // pop
        send(32'h0000_0044, 48'h50_26_80_00_00_00);   // load
        send(32'h0000_0046, 48'h90_FF_01_02_03_04);   // return
        idle(3);
        chk("R9 valid low end", dec_valid, 1'b0);
        chk("R9 class hold end", op_class, last.opc);
        chk("R8 queue drained", 64'(q.size()), 64'd0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule